// File: doc/BRIEF.md
# Three-Level Thermal Protection Comparator

This block watches filtered 12-bit raw readings from on-chip temperature sensing points. It compares each reading against three programmable raw thresholds per bank: cold, middle and hot. The raw code of the sensor falls as the die heats. A hot or middle condition is therefore a reading at or below its threshold, and a cold condition is a reading at or above its threshold. Each bank has its own thresholds, level enables and sticky status. A new reading is evaluated only in the cycle it arrives, and only against the bank it is tagged with.

Software programs thresholds and enables through a small register port. A 4-bit bank field chooses which bank a register access reaches. Software reads a bank's status to learn which levels fired, and that read also clears the status. An active-low per-bank pending vector is driven on a port and can also be read as a summary word. While any bank holds a hot event, a level output requests a system reset. The conversion between temperature and raw code is done by software and is not part of the block.

Top module: `thermProtect`

## Requirements
- R1: After reset every bank has cold threshold 0xFFF, middle and hot thresholds 0, all level enables off and status 0. `irqPendN` is all ones, `resetReq` is 0 and `regRdata` is 0.
- R2: Register addresses per bank are 0 cold threshold, 1 middle threshold, 2 hot threshold, 3 level-enable word and 4 status. Thresholds keep and return only bits [11:0], and the other read bits are 0. The enable word keeps only bits 31 (hot), 30 (middle) and 29 (cold), and the other read bits are 0.
- R3: A reading whose low 12 bits are less than or equal to the hot threshold sets status bit 2 if the hot enable is set.
- R4: A reading whose low 12 bits are less than or equal to the middle threshold sets status bit 1 if the middle enable is set.
- R5: A reading whose low 12 bits are greater than or equal to the cold threshold sets status bit 0 if the cold enable is set.
- R6: A disabled level never sets its status bit. Rewriting the enable word does not change any threshold, so an unused middle level keeps its old threshold.
- R7: A reading is evaluated only in the cycle `measValid` is high, and only for the bank given by `measBank`. Other banks are left unchanged.
- R8: Bits of `measRaw` above bit 11 have no effect on any comparison.
- R9: Status bits are sticky. A read of address 4 returns the bank's status and clears it. An event in the same cycle as the clearing read is kept for the next read.
- R10: Bit n of `irqPendN` is 0 exactly when bank n has a status bit set. Address 5 returns the same vector in bits [3:0] for any bank field, with the other bits 0.
- R11: `resetReq` is 1 while any bank's hot status bit is set. It falls once that status has been cleared.
- R12: A bank field of 4 or more makes writes have no effect, and reads at addresses 0 to 4 return 0.
- R13: Read data appears in the cycle after `regRe` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regBank | input | 4 | Bank select for the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| measValid | input | 1 | New filtered reading present |
| measBank | input | 2 | Bank the reading belongs to |
| measRaw | input | 16 | Raw reading, only bits [11:0] compared |
| irqPendN | output | 4 | Per-bank pending flag, active low |
| resetReq | output | 1 | System reset request, held while a hot event is pending |

## Verification
Every raw code from 0 to 4095 is driven into each bank, with junk in the upper bits. Each bank has different thresholds and a different set of enabled levels. One of the four enable sets leaves the middle level unused. Because of this, a fault at a comparison edge, in the direction of a comparison, or in the gating of a level shows up at one exact code in one exact bank. After each reading the pending vector and the reset request are compared with the arithmetic expectation. This exposes a reading that reaches the wrong bank. Directed sequences then cover accumulation across readings, a clearing read that collides with a new event, accesses to out-of-range banks, and readback of the field masks.

// File: rtl/thermPkg.sv
package thermPkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int SEL_W     = 4;
  localparam int RAW_W     = 12;
  localparam int MEAS_W    = 16;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 32;
  localparam int LVL_N     = 3;
  localparam int EN_LSB    = DATA_W - LVL_N;

  localparam int IDX_COLD = 0;
  localparam int IDX_MID  = 1;
  localparam int IDX_HOT  = 2;

  localparam logic [ADDR_W-1:0] ADDR_COLD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MID  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STS  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SUM  = 3'd5;

  typedef enum logic [2:0] {
    RD_COLD = 3'd0,
    RD_MID  = 3'd1,
    RD_HOT  = 3'd2,
    RD_EN   = 3'd3,
    RD_STS  = 3'd4,
    RD_SUM  = 3'd5,
    RD_NONE = 3'd7
  } rdSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] wrCold;
    logic [NUM_BANKS-1:0] wrMid;
    logic [NUM_BANKS-1:0] wrHot;
    logic [NUM_BANKS-1:0] wrEn;
    logic [NUM_BANKS-1:0] clrSts;
    logic [NUM_BANKS-1:0] evalBank;
    logic                 rdStb;
    rdSel_e               rdSel;
    logic [BANK_W-1:0]    rdBank;
  } ctrlStb_t;
endpackage

// File: rtl/thermCtrl.sv
module thermCtrl
  import thermPkg::*;
(
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SEL_W-1:0]  regBank,
  input  logic              measValid,
  input  logic [BANK_W-1:0] measBank,
  output ctrlStb_t          stb
);
  logic              bankOk;
  logic [BANK_W-1:0] bankIdx;
  logic              unusedSelBits;

  assign bankOk        = (regBank < SEL_W'(NUM_BANKS));
  assign bankIdx       = regBank[BANK_W-1:0];
  assign unusedSelBits = ^regBank;

  always_comb begin
    stb        = '0;
    stb.rdSel  = RD_NONE;
    stb.rdBank = bankIdx;
    stb.rdStb  = regRe;
    for (int b = 0; b < NUM_BANKS; b++) begin
      stb.wrCold[b]   = regWe && bankOk && (bankIdx == BANK_W'(b)) && (regAddr == ADDR_COLD);
      stb.wrMid[b]    = regWe && bankOk && (bankIdx == BANK_W'(b)) && (regAddr == ADDR_MID);
      stb.wrHot[b]    = regWe && bankOk && (bankIdx == BANK_W'(b)) && (regAddr == ADDR_HOT);
      stb.wrEn[b]     = regWe && bankOk && (bankIdx == BANK_W'(b)) && (regAddr == ADDR_EN);
      stb.clrSts[b]   = regRe && bankOk && (bankIdx == BANK_W'(b)) && (regAddr == ADDR_STS);
      stb.evalBank[b] = measValid && (measBank == BANK_W'(b));
    end
    case (regAddr)
      ADDR_COLD: if (bankOk) stb.rdSel = RD_COLD;
      ADDR_MID:  if (bankOk) stb.rdSel = RD_MID;
      ADDR_HOT:  if (bankOk) stb.rdSel = RD_HOT;
      ADDR_EN:   if (bankOk) stb.rdSel = RD_EN;
      ADDR_STS:  if (bankOk) stb.rdSel = RD_STS;
      ADDR_SUM:  stb.rdSel = RD_SUM;
      default:   stb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/thermBankCmp.sv
module thermBankCmp
  import thermPkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  logic [RAW_W-1:0] thrCold,
  input  logic [RAW_W-1:0] thrMid,
  input  logic [RAW_W-1:0] thrHot,
  input  logic [LVL_N-1:0] lvlEn,
  output logic [LVL_N-1:0] hit
);
  // Raw code falls as temperature rises: hot/middle fire at or below, cold at or above.
  always_comb begin
    hit           = '0;
    hit[IDX_HOT]  = lvlEn[IDX_HOT]  && (raw <= thrHot);
    hit[IDX_MID]  = lvlEn[IDX_MID]  && (raw <= thrMid);
    hit[IDX_COLD] = lvlEn[IDX_COLD] && (raw >= thrCold);
  end
endmodule

// File: rtl/thermDatapath.sv
module thermDatapath
  import thermPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [MEAS_W-1:0]    measRaw,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_BANKS-1:0] irqPendN,
  output logic                 resetReq
);
  logic [RAW_W-1:0] rawLo;
  logic             unusedHighBits;
  logic [NUM_BANKS-1:0][RAW_W-1:0] thrColdV;
  logic [NUM_BANKS-1:0][RAW_W-1:0] thrMidV;
  logic [NUM_BANKS-1:0][RAW_W-1:0] thrHotV;
  logic [NUM_BANKS-1:0][LVL_N-1:0] lvlEnV;
  logic [NUM_BANKS-1:0][LVL_N-1:0] stsV;
  logic [NUM_BANKS-1:0]            hotV;
  logic [DATA_W-1:0]               rdNext;

  assign rawLo          = measRaw[RAW_W-1:0];
  assign unusedHighBits = ^{measRaw[MEAS_W-1:RAW_W], wdata[EN_LSB-1:RAW_W]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [RAW_W-1:0] thrColdQ;
    logic [RAW_W-1:0] thrMidQ;
    logic [RAW_W-1:0] thrHotQ;
    logic [LVL_N-1:0] lvlEnQ;
    logic [LVL_N-1:0] stsQ;
    logic [LVL_N-1:0] hitNow;

    thermBankCmp u_cmp (
      .raw     (rawLo),
      .thrCold (thrColdQ),
      .thrMid  (thrMidQ),
      .thrHot  (thrHotQ),
      .lvlEn   (lvlEnQ),
      .hit     (hitNow)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        thrColdQ <= '1;
        thrMidQ  <= '0;
        thrHotQ  <= '0;
        lvlEnQ   <= '0;
        stsQ     <= '0;
      end else begin
        if (stb.wrCold[b]) thrColdQ <= wdata[RAW_W-1:0];
        if (stb.wrMid[b])  thrMidQ  <= wdata[RAW_W-1:0];
        if (stb.wrHot[b])  thrHotQ  <= wdata[RAW_W-1:0];
        if (stb.wrEn[b])   lvlEnQ   <= wdata[DATA_W-1:EN_LSB];
        // a new event wins over a clearing read in the same cycle
        stsQ <= (stb.clrSts[b] ? '0 : stsQ) | (stb.evalBank[b] ? hitNow : '0);
      end
    end

    assign thrColdV[b] = thrColdQ;
    assign thrMidV[b]  = thrMidQ;
    assign thrHotV[b]  = thrHotQ;
    assign lvlEnV[b]   = lvlEnQ;
    assign stsV[b]     = stsQ;
    assign irqPendN[b] = ~|stsQ;
    assign hotV[b]     = stsQ[IDX_HOT];
  end

  assign resetReq = |hotV;

  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      RD_COLD: rdNext = DATA_W'(thrColdV[stb.rdBank]);
      RD_MID:  rdNext = DATA_W'(thrMidV[stb.rdBank]);
      RD_HOT:  rdNext = DATA_W'(thrHotV[stb.rdBank]);
      RD_EN:   rdNext = {lvlEnV[stb.rdBank], {EN_LSB{1'b0}}};
      RD_STS:  rdNext = DATA_W'(stsV[stb.rdBank]);
      RD_SUM:  rdNext = DATA_W'(irqPendN);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (stb.rdStb) rdata <= rdNext;
  end
endmodule

// File: rtl/thermProtect.sv
module thermProtect
  import thermPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic                 regRe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [SEL_W-1:0]     regBank,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic                 measValid,
  input  logic [BANK_W-1:0]    measBank,
  input  logic [MEAS_W-1:0]    measRaw,
  output logic [NUM_BANKS-1:0] irqPendN,
  output logic                 resetReq
);
  ctrlStb_t stb;

  thermCtrl u_ctrl (
    .regWe     (regWe),
    .regRe     (regRe),
    .regAddr   (regAddr),
    .regBank   (regBank),
    .measValid (measValid),
    .measBank  (measBank),
    .stb       (stb)
  );

  thermDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (regWdata),
    .measRaw  (measRaw),
    .rdata    (regRdata),
    .irqPendN (irqPendN),
    .resetReq (resetReq)
  );
endmodule

// File: rtl/thermProtect_chk.sv
module thermProtect_chk
  import thermPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regRe,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regRdata,
  input logic                 measValid,
  input logic [NUM_BANKS-1:0] irqPendN,
  input logic                 resetReq
);
  p_reset_rise_needs_meas_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(measValid));

  p_new_pending_needs_meas_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(measValid) |-> ((~irqPendN & $past(irqPendN)) == '0));

  p_pending_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(measValid) && !$past(regRe)) |-> $stable(irqPendN));

  p_reset_has_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (irqPendN != '1));

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regRe) |-> $stable(regRdata));

  p_en_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regRe) && ($past(regAddr) == ADDR_EN)) |-> (regRdata[EN_LSB-1:0] == '0));
endmodule

bind thermProtect thermProtect_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regRe     (regRe),
  .regAddr   (regAddr),
  .regRdata  (regRdata),
  .measValid (measValid),
  .irqPendN  (irqPendN),
  .resetReq  (resetReq)
);

// File: tb/thermProtect_bench.sv
module thermProtect_bench;
  import thermPkg::*;

  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 regWe = 1'b0;
  logic                 regRe = 1'b0;
  logic [ADDR_W-1:0]    regAddr = '0;
  logic [SEL_W-1:0]     regBank = '0;
  logic [DATA_W-1:0]    regWdata = '0;
  logic [DATA_W-1:0]    regRdata;
  logic                 measValid = 1'b0;
  logic [BANK_W-1:0]    measBank = '0;
  logic [MEAS_W-1:0]    measRaw = '0;
  logic [NUM_BANKS-1:0] irqPendN;
  logic                 resetReq;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  int          thrA [NUM_BANKS] = '{3000, 3100, 3200, 3300};
  int          thrB [NUM_BANKS] = '{1500, 1550, 1600, 1650};
  int          thrC [NUM_BANKS] = '{800, 837, 874, 911};
  logic [2:0]  enSet[NUM_BANKS] = '{3'b111, 3'b101, 3'b111, 3'b110};

  always #(CLK_PERIOD/2) clk = ~clk;

  thermProtect u_thermProtect (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regBank(regBank), .regWdata(regWdata), .regRdata(regRdata),
    .measValid(measValid), .measBank(measBank), .measRaw(measRaw),
    .irqPendN(irqPendN), .resetReq(resetReq)
  );

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic regWrite(int bank, logic [ADDR_W-1:0] addr, logic [31:0] data);
    regWe = 1'b1; regBank = SEL_W'(bank); regAddr = addr; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(int bank, logic [ADDR_W-1:0] addr, output logic [31:0] data);
    regRe = 1'b1; regBank = SEL_W'(bank); regAddr = addr;
    @(negedge clk);
    regRe = 1'b0;
    data = regRdata;
  endtask

  task automatic measure(int bank, logic [MEAS_W-1:0] raw);
    measValid = 1'b1; measBank = BANK_W'(bank); measRaw = raw;
    @(negedge clk);
    measValid = 1'b0;
  endtask

  function automatic logic [2:0] expSts(int raw, int b);
    logic [2:0] e;
    e[2] = enSet[b][2] && (raw <= thrC[b]);
    e[1] = enSet[b][1] && (raw <= thrB[b]);
    e[0] = enSet[b][0] && (raw >= thrA[b]);
    return e;
  endfunction

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=finish", WATCHDOG_CYC);
      finishRun();
    end
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkEq("R1 irqPendN", 32'(irqPendN), 32'hF);
    checkEq("R1 resetReq", 32'(resetReq), 32'h0);
    checkEq("R1 rdata", regRdata, 32'h0);
    regRead(3, ADDR_COLD, d); checkEq("R1 cold thr", d, 32'hFFF);
    regRead(3, ADDR_MID, d);  checkEq("R1 mid thr", d, 32'h0);
    regRead(0, ADDR_HOT, d);  checkEq("R1 hot thr", d, 32'h0);
    regRead(0, ADDR_EN, d);   checkEq("R1 enables", d, 32'h0);
    regRead(2, ADDR_STS, d);  checkEq("R1 status", d, 32'h0);

    // R2: field masks
    regWrite(0, ADDR_COLD, 32'hFFFF_FABC);
    regRead(0, ADDR_COLD, d); checkEq("R2 cold mask", d, 32'h0000_0ABC);
    regWrite(0, ADDR_EN, 32'hFFFF_FFFF);
    regRead(0, ADDR_EN, d);   checkEq("R2 enable mask", d, 32'hE000_0000);

    // program sweep configuration
    for (int b = 0; b < NUM_BANKS; b++) begin
      regWrite(b, ADDR_COLD, 32'(thrA[b]));
      regWrite(b, ADDR_MID,  32'(thrB[b]));
      regWrite(b, ADDR_HOT,  32'(thrC[b]));
      regWrite(b, ADDR_EN,   {enSet[b], 29'h0});
    end

    // R6: enable rewrite leaves the unused middle threshold intact
    regRead(1, ADDR_MID, d); checkEq("R6 mid kept", d, 32'(thrB[1]));
    regRead(3, ADDR_HOT, d); checkEq("R2 hot readback", d, 32'(thrC[3]));

    // R3 R4 R5 R6 R7 R8 R10 R11: exhaustive sweep of raw codes per bank
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int r = 0; r < 4096; r++) begin
        measure(b, {4'(r * 5 + b + 1), 12'(r)});
        e = expSts(r, b);
        checkEq($sformatf("R7 R10 pend bank%0d raw%0d", b, r), 32'(irqPendN),
                32'(4'hF & ~((e != 3'b000) ? (4'b0001 << b) : 4'b0000)));
        checkEq($sformatf("R11 resetReq bank%0d raw%0d", b, r), 32'(resetReq), 32'(e[2]));
        regRead(b, ADDR_STS, d);
        checkEq($sformatf("R3 R4 R5 R8 status bank%0d raw%0d", b, r), d, 32'(e));
      end
    end
    checkEq("R11 resetReq cleared", 32'(resetReq), 32'h0);
    checkEq("R9 pend cleared", 32'(irqPendN), 32'hF);

    // R9: accumulation, and clearing read colliding with a new event
    measure(0, 16'd3500);
    measure(0, 16'd100);
    regRead(0, ADDR_STS, d); checkEq("R9 sticky accumulate", d, 32'h7);
    measure(2, 16'd3500);
    measValid = 1'b1; measBank = 2'd2; measRaw = 16'd10;
    regRe = 1'b1; regBank = 4'd2; regAddr = ADDR_STS;
    @(negedge clk);
    measValid = 1'b0; regRe = 1'b0;
    checkEq("R9 collide old status", regRdata, 32'h1);
    checkEq("R11 resetReq after collide", 32'(resetReq), 32'h1);

    // R10: summary word for any bank field
    regRead(9, ADDR_SUM, d); checkEq("R10 summary", d, 32'h0000_000B);
    regRead(2, ADDR_STS, d); checkEq("R9 collide new status", d, 32'h6);

    // R13: read data holds without a read
    @(negedge clk);
    checkEq("R13 rdata hold", regRdata, 32'h6);

    // R12: out-of-range bank field
    regWrite(4, ADDR_COLD, 32'h0000_0123);
    regWrite(12, ADDR_EN, 32'h0);
    regRead(0, ADDR_COLD, d); checkEq("R12 no alias write", d, 32'(thrA[0]));
    regRead(0, ADDR_EN, d);   checkEq("R12 no alias enable", d, {enSet[0], 29'h0});
    regRead(4, ADDR_COLD, d); checkEq("R12 read zero", d, 32'h0);

    // R7: a reading for bank 1 leaves bank 3 untouched
    measure(1, 16'd0);
    regRead(3, ADDR_STS, d); checkEq("R7 other bank", d, 32'h0);
    regRead(1, ADDR_STS, d); checkEq("R6 mid disabled", d, 32'h4);

    finishRun();
  end
endmodule